// File: doc/BRIEF.md
# Real-Time Clock Event Status and Interrupt Enable

This block holds the event flags and the interrupt masking for a real-time clock. Single-cycle event pulses from the timekeeping core (stopwatch, alarm, second, minute, hour, day rollover, day alarm) and the completion pulse from the slow register write synchronizer each latch a sticky status bit. The host clears status bits by writing ones, and the clear takes effect on the next clock edge. The host can also read a live "write in flight" flag from the synchronizer in the same register.

The interrupt enable register shares the status bit layout. Writes to it do not take effect at once. A host write is parked in a one-entry staging slot and copied into the live enable register on the next slow tick. A second write that arrives while the slot is still occupied is dropped. The single interrupt output is high whenever any readable status bit has its enable bit set. Status bits latch whether or not they are enabled, so software can poll events it has masked.

Top module: `rtc_evt_irq`

## Requirements
- R1: After reset, status read-back, enable read-back and the interrupt output are all 0 (with the synchronizer busy input low).
- R2: A pulse on `tm_evt[i]` (i = 0..6) sets status bit i, and a pulse on `sync_done` sets status bit 15, at the next clock edge, whatever the enable bits hold. Bit map: 0 stopwatch, 1 alarm, 2 second, 3 minute, 4 hour, 5 day rollover, 6 day alarm, 14 write pending, 15 write complete.
- R3: A status write with a 1 in a latched bit clears that bit at the next edge; a 0 leaves it unchanged.
- R4: When an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 14 always reads the live `sync_busy` input and is unaffected by status writes; status bits 7 to 13 always read 0.
- R6: An enable write is held in a staging slot and appears on `en_rd` only after the first clock edge at which `slow_tick` is high and the slot is occupied; only bits 0–6, 14 and 15 are stored, the rest read 0.
- R7: An enable write that arrives while the staging slot is occupied is discarded.
- R8: `irq` is high exactly when some bit is 1 in both the status read-back and the enable read-back.
- R9: Writing 0xFFFF to status clears every latched event bit in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tm_evt | input | 7 | Timekeeping event pulses, bit i sets status bit i |
| sync_done | input | 1 | Write-complete pulse from the synchronizer |
| sync_busy | input | 1 | Live write-in-flight flag from the synchronizer |
| stat_wr | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | 16 | Status write data |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 16 | Enable write data |
| slow_tick | input | 1 | Slow commit tick for enable writes |
| stat_rd | output | 16 | Status read-back |
| en_rd | output | 16 | Live enable read-back |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit register and seven timekeeping events, which place every event bit, the pending bit and the write-complete bit at their real positions. With these values each latched bit, the reserved gap 7 to 13 and the live pending bit can be driven and read directly, and the staging slot can be filled, hit by a second write, and committed by a tick, so drop and commit ordering are exercised cycle by cycle.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  parameter int REG_W      = 16;
  parameter int NUM_TM_EVT = 7;
  parameter int BIT_PEND   = 14;
  parameter int BIT_DONE   = 15;

  // bits that hold latched event state
  function automatic logic [REG_W-1:0] latch_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_TM_EVT; i++) m[i] = 1'b1;
    m[BIT_DONE] = 1'b1;
    return m;
  endfunction

  // bits that the enable register stores
  function automatic logic [REG_W-1:0] enable_mask();
    logic [REG_W-1:0] m;
    m = latch_mask();
    m[BIT_PEND] = 1'b1;
    return m;
  endfunction

  // place the event pulses at their status positions
  function automatic logic [REG_W-1:0] set_vector(logic [NUM_TM_EVT-1:0] tm, logic done);
    logic [REG_W-1:0] v;
    v = '0;
    v[NUM_TM_EVT-1:0] = tm;
    v[BIT_DONE] = done;
    return v;
  endfunction
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import rtc_evt_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_d;

  always_comb begin
    stat_d = ((stat_q & ~clr_vec) | set_vec) & latch_mask();
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R4
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(stat_q)); // R3
endmodule

// File: rtl/irq_enable_stage.sv
module irq_enable_stage
  import rtc_evt_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  output logic [W-1:0] en_q
);
  logic         slot_full;
  logic [W-1:0] slot_q;
  logic         accept;
  logic         commit;

  assign accept = wr && !slot_full;
  assign commit = tick && slot_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_full <= 1'b0;
      slot_q    <= '0;
      en_q      <= '0;
    end else begin
      if (commit) begin
        en_q      <= slot_q;
        slot_full <= 1'b0;
      end else if (accept) begin
        slot_q    <= wdata & enable_mask();
        slot_full <= 1'b1;
      end
    end
  end

  AST_EN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(en_q)); // R6
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_full && wr) |=> $stable(slot_q)); // R7
endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
  import rtc_evt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TM_EVT-1:0] tm_evt,
  input  logic                  sync_done,
  input  logic                  sync_busy,
  input  logic                  stat_wr,
  input  logic [REG_W-1:0]      stat_wdata,
  input  logic                  en_wr,
  input  logic [REG_W-1:0]      en_wdata,
  input  logic                  slow_tick,
  output logic [REG_W-1:0]      stat_rd,
  output logic [REG_W-1:0]      en_rd,
  output logic                  irq
);
  logic [REG_W-1:0] ev_set;
  logic [REG_W-1:0] ev_clr;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] hit_vec;

  assign ev_set = set_vector(tm_evt, sync_done);
  assign ev_clr = stat_wr ? stat_wdata : '0;

  evt_status_reg #(.W(REG_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(ev_set), .clr_vec(ev_clr), .stat_q(stat_q)
  );

  irq_enable_stage #(.W(REG_W)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata),
    .tick(slow_tick), .en_q(en_rd)
  );

  always_comb begin
    stat_rd = stat_q;
    stat_rd[BIT_PEND] = sync_busy;
  end

  assign hit_vec = stat_rd & en_rd;
  assign irq     = |hit_vec;

  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[BIT_PEND-1:NUM_TM_EVT] == '0); // R5
  AST_PEND_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[BIT_PEND] == sync_busy); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rd == '0) |-> !irq); // R8
endmodule

// File: tb/rtc_evt_irq_bench.sv
module rtc_evt_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  tm_evt = '0;
  logic        sync_done = 1'b0;
  logic        sync_busy = 1'b0;
  logic        stat_wr = 1'b0;
  logic [15:0] stat_wdata = '0;
  logic        en_wr = 1'b0;
  logic [15:0] en_wdata = '0;
  logic        slow_tick = 1'b0;
  logic [15:0] stat_rd, en_rd;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_evt_irq u_rtc_evt_irq (
    .clk(clk), .rst_n(rst_n), .tm_evt(tm_evt), .sync_done(sync_done),
    .sync_busy(sync_busy), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata), .slow_tick(slow_tick),
    .stat_rd(stat_rd), .en_rd(en_rd), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock edge; inputs were set away from the edge, sample after it
  task automatic step();
    @(posedge clk); #1;
    tm_evt = '0; sync_done = 0; stat_wr = 0; stat_wdata = '0;
    en_wr = 0; en_wdata = '0; slow_tick = 0;
  endtask

  task automatic clear_all();
    stat_wr = 1; stat_wdata = 16'hFFFF; step();
  endtask

  task automatic t_reset();
    chk("R1 status", stat_rd, 16'h0);
    chk("R1 enable", en_rd, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_events_unmasked();
    for (int i = 0; i < 7; i++) begin
      tm_evt = 7'(1 << i); step();
      chk("R2 event bit", stat_rd, 16'(1 << i));
      chk("R2 no irq while masked", {15'b0, irq}, 16'h0);
      clear_all();
    end
    sync_done = 1; step();
    chk("R2 write complete bit 15", stat_rd, 16'h8000);
    clear_all();
  endtask

  task automatic t_w1c();
    tm_evt = 7'h7F; sync_done = 1; step();
    stat_wr = 1; stat_wdata = 16'h0005; step();
    chk("R3 clear ones only", stat_rd, 16'h807A);
    stat_wr = 1; stat_wdata = 16'h0000; step();
    chk("R3 zero write keeps", stat_rd, 16'h807A);
    clear_all();
    chk("R9 clear all", stat_rd, 16'h0000);
  endtask

  task automatic t_set_wins();
    tm_evt = 7'h04; step();
    tm_evt = 7'h04; stat_wr = 1; stat_wdata = 16'h0004; step();
    chk("R4 set beats clear", stat_rd, 16'h0004);
    tm_evt = 7'h08; stat_wr = 1; stat_wdata = 16'hFFFF; step();
    chk("R4 set beats clear-all", stat_rd, 16'h0008);
    clear_all();
  endtask

  task automatic t_pending();
    sync_busy = 1; #1;
    chk("R5 pending live", stat_rd, 16'h4000);
    stat_wr = 1; stat_wdata = 16'h4000; step();
    chk("R5 pending not cleared", stat_rd, 16'h4000);
    sync_busy = 0; #1;
    chk("R5 pending follows input", stat_rd, 16'h0000);
    stat_wr = 1; stat_wdata = 16'h3F80; tm_evt = 7'h7F; step();
    chk("R5 gap bits zero", stat_rd & 16'h3F80, 16'h0000);
    clear_all();
  endtask

  task automatic t_enable();
    en_wr = 1; en_wdata = 16'hFFFF; step();
    chk("R6 no effect before tick", en_rd, 16'h0000);
    step();
    chk("R6 still waiting", en_rd, 16'h0000);
    slow_tick = 1; step();
    chk("R6 commit masked", en_rd, 16'hC07F);
    en_wr = 1; en_wdata = 16'h0004; step();
    en_wr = 1; en_wdata = 16'h0002; step();
    slow_tick = 1; step();
    chk("R7 second write dropped", en_rd, 16'h0004);
    slow_tick = 1; step();
    chk("R7 no late commit", en_rd, 16'h0004);
  endtask

  task automatic t_irq();
    // enable holds 0x0004 (second)
    tm_evt = 7'h02; step();
    chk("R8 masked event quiet", {15'b0, irq}, 16'h0);
    tm_evt = 7'h04; step();
    chk("R8 enabled event fires", {15'b0, irq}, 16'h1);
    stat_wr = 1; stat_wdata = 16'h0004; step();
    chk("R8 clear drops irq", {15'b0, irq}, 16'h0);
    chk("R3 other bit kept", stat_rd, 16'h0002);
    en_wr = 1; en_wdata = 16'h4000; step();
    slow_tick = 1; step();
    sync_busy = 1; #1;
    chk("R8 pending bit fires", {15'b0, irq}, 16'h1);
    sync_busy = 0; #1;
    chk("R8 pending low quiet", {15'b0, irq}, 16'h0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_events_unmasked();
    t_w1c();
    t_set_wins();
    t_pending();
    t_enable();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule